// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds the eight control bits that steer a microcontroller's clock generator. The bits select the system clock source, divide the main clock by eight, stop the main oscillator, enable the sub-clock oscillator on its pins, set the sub-clock drive strength, and gate peripheral clocks during wait mode. The CPU writes the register through a byte-wide port with a one-cycle write strobe. Stored values, and the bits that hardware forces, appear at once on a read bus and on individual decoded outputs.

Two guards limit software writes. A protect input must be high for any write to land. A clock-modification lock, while high, freezes the source-select bit, the main-stop bit and the wait-mode gating bit, and the other bits still update. Hardware may also override software. Entering stop mode forces divide-by-eight and high sub-clock drive. Choosing port mode instead of the sub-oscillator forces high drive. With the ring oscillator disabled and the main clock stopped, divide-by-eight is held set, and a companion drive-capability flag tells the divider logic to hold its own drive bit high.

Top module: `sck_reg`

## Requirements
- R1: After synchronous active-low reset the read value is 0x48: bit 6 (divide-by-8) and bit 3 (high sub-clock drive) are set, and all other bits are 0.
- R2: A write strobe while the protect input is 0 leaves every bit unchanged.
- R3: While the lock input is 1, a write leaves bit 7 (system clock select, 1 = sub-clock), bit 5 (main clock stop, 1 = off) and bit 2 (stop peripheral clock in wait) unchanged, and still updates bits 6, 4 and 3.
- R4: Whenever bit 4 (sub-oscillator select, 0 = port mode) is 0, bit 3 reads 1, even if 0 was written to it.
- R5: A stop-mode entry pulse sets bits 6 and 3 on the next clock edge, and it overrides a write to those bits in the same cycle.
- R6: While the ring-oscillator-enabled input is 0 and bit 5 is 1, bit 6 reads 1, writing 0 to it does not clear it, and the drive-capability hold output is 1. Otherwise that output is 0.
- R7: Bits 1 and 0 always read 0, whatever is written.
- R8: An accepted write stores the written byte, subject to R3, R4, R5 and R7, on the next rising clock edge. Each decoded output equals its bit of the read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Write data byte |
| prot_wen | input | 1 | Protect input; 1 lets writes take effect |
| clk_lock | input | 1 | Clock-modification lock for bits 7, 5, 2 |
| stop_enter | input | 1 | One-cycle stop-mode entry pulse |
| ring_osc_on | input | 1 | 1 while the ring oscillator is enabled |
| rd_data | output | 8 | Effective register value including forced bits |
| sysclk_sub | output | 1 | System clock from sub-clock |
| div8_sel | output | 1 | Main clock divide-by-8 selected |
| main_stop | output | 1 | Main oscillator stopped |
| sub_osc_en | output | 1 | Sub-oscillator function on pins (0 = port) |
| sub_drive_hi | output | 1 | Sub-clock drive capacity high |
| wait_pclk_stop | output | 1 | Stop peripheral clock in wait mode |
| main_drive_hold | output | 1 | Hold the divider's drive-capability bit high |

## Verification
A byte with mixed ones and zeros, written with the protect input high, shows that each bit lands in its own position and that the reserved bits are dropped. Writing all ones and then all zeros with the lock set, starting once from cleared and once from set locked bits, separates the bits that are frozen from those that still follow the data. A write that clears bit 3 while bit 4 is 1 is compared with one that clears both, which separates the port-mode forcing from the stored value. A stop pulse is applied alone and then together with a write that clears bits 6 and 3, which shows that the forcing wins. With the ring oscillator disabled, the main-stop condition is checked against a write that tries to clear divide-by-8.

// File: rtl/sck_pkg.sv
// Package: bit positions, masks, reset value and decoded view of the
// system clock control register. Assumes an 8-bit register.
package sck_pkg;
    localparam int REG_W   = 8;
    localparam int B_SYS   = 7;
    localparam int B_DIV8  = 6;
    localparam int B_MSTOP = 5;
    localparam int B_SUBEN = 4;
    localparam int B_SDRV  = 3;
    localparam int B_WPCLK = 2;

    localparam logic [REG_W-1:0] RST_VAL   = 8'h48;
    localparam logic [REG_W-1:0] LOCK_MASK = (REG_W'(1) << B_SYS) |
                                             (REG_W'(1) << B_MSTOP) |
                                             (REG_W'(1) << B_WPCLK);
    localparam logic [REG_W-1:0] RSV_MASK  = 8'h03;

    typedef struct packed {
        logic       sys_sub;
        logic       div8;
        logic       main_stop;
        logic       sub_en;
        logic       sub_drv_hi;
        logic       wait_pclk_stop;
        logic [1:0] rsv;
    } ctl_t;
endpackage

// File: rtl/sck_wr_merge.sv
// Write merge: forms the candidate next value from the current value and
// an accepted CPU write. Locked bits keep the current value, and reserved
// bits are cleared. Assumes wr_acc already includes the protect check.
module sck_wr_merge
    import sck_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wr_data,
    input  logic         wr_acc,
    input  logic         lock,
    output logic [W-1:0] cand
);
    logic [W-1:0] keep;

    // Choose which bits the lock preserves.
    always_comb keep = lock ? W'(LOCK_MASK) : '0;

    // Merge write data with preserved bits and drop reserved bits.
    always_comb begin
        if (wr_acc)
            cand = ((wr_data & ~keep) | (cur & keep)) & ~W'(RSV_MASK);
        else
            cand = cur;
    end
endmodule

// File: rtl/sck_force.sv
// Force rules: applies hardware overrides to the candidate next value.
// The overrides cover stop entry, port-mode drive and the divide-by-8 hold
// while the ring oscillator is off and the main clock is stopped. They
// take priority over any write merged into cand.
module sck_force
    import sck_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] cand,
    input  logic         stop_enter,
    input  logic         ring_osc_on,
    output logic [W-1:0] nxt
);
    // Apply each forced-bit rule on top of the candidate.
    always_comb begin
        nxt = cand;
        if (stop_enter) begin
            nxt[B_DIV8] = 1'b1;
            nxt[B_SDRV] = 1'b1;
        end
        if (!nxt[B_SUBEN])
            nxt[B_SDRV] = 1'b1;
        if (!ring_osc_on && nxt[B_MSTOP])
            nxt[B_DIV8] = 1'b1;
        nxt &= ~W'(RSV_MASK);
    end
endmodule

// File: rtl/sck_reg.sv
// Top: protected system clock control register. It stores the control byte,
// gates writes with the protect input, and applies the lock and forcing
// rules. It drives the effective value and the decoded controls.
// Assumes single-cycle write and stop pulses synchronous to clk.
module sck_reg
    import sck_pkg::*;
#(
    parameter logic [REG_W-1:0] RESET_VALUE = RST_VAL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             prot_wen,
    input  logic             clk_lock,
    input  logic             stop_enter,
    input  logic             ring_osc_on,
    output logic [REG_W-1:0] rd_data,
    output logic             sysclk_sub,
    output logic             div8_sel,
    output logic             main_stop,
    output logic             sub_osc_en,
    output logic             sub_drive_hi,
    output logic             wait_pclk_stop,
    output logic             main_drive_hold
);
    logic [REG_W-1:0] q;
    logic [REG_W-1:0] cand;
    logic [REG_W-1:0] nxt;
    logic             wr_acc;
    ctl_t             ctl;

    // Accept a write only while the protect input allows it.
    always_comb wr_acc = wr_en && prot_wen;

    sck_wr_merge #(.W(REG_W)) u_merge (
        .cur     (q),
        .wr_data (wr_data),
        .wr_acc  (wr_acc),
        .lock    (clk_lock),
        .cand    (cand)
    );

    sck_force #(.W(REG_W)) u_force (
        .cand        (cand),
        .stop_enter  (stop_enter),
        .ring_osc_on (ring_osc_on),
        .nxt         (nxt)
    );

    // Storage register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RESET_VALUE;
        else        q <= nxt;
    end

    // Hold condition: ring oscillator off while the main clock is stopped.
    always_comb main_drive_hold = !ring_osc_on && q[B_MSTOP];

    // Effective read value, with divide-by-8 held under the hold condition.
    always_comb begin
        rd_data         = q;
        rd_data[B_DIV8] = q[B_DIV8] | main_drive_hold;
    end

    // Decode the effective value into named controls.
    always_comb begin
        ctl            = ctl_t'(rd_data);
        sysclk_sub     = ctl.sys_sub;
        div8_sel       = ctl.div8;
        main_stop      = ctl.main_stop;
        sub_osc_en     = ctl.sub_en;
        sub_drive_hi   = ctl.sub_drv_hi;
        wait_pclk_stop = ctl.wait_pclk_stop;
    end
endmodule

// File: rtl/sck_reg_chk.sv
// Checker: temporal properties of the system clock control register,
// attached to sck_reg through bind. Observes ports only.
module sck_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       prot_wen,
    input logic       clk_lock,
    input logic       stop_enter,
    input logic       ring_osc_on,
    input logic [7:0] rd_data,
    input logic       sysclk_sub,
    input logic       div8_sel,
    input logic       main_stop,
    input logic       sub_osc_en,
    input logic       sub_drive_hi,
    input logic       wait_pclk_stop,
    input logic       main_drive_hold
);
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[1:0] == 2'b00); // R7
    AST_UNPROT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !prot_wen && !stop_enter) |=> ($stable(rd_data[5:0]) && $stable(rd_data[7]))); // R2
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clk_lock) |=> ($stable(rd_data[7]) && $stable(rd_data[5]) && $stable(rd_data[2]))); // R3
    AST_PORT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) !rd_data[4] |-> rd_data[3]); // R4
    AST_STOP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_enter |=> (rd_data[6] && rd_data[3])); // R5
    AST_DIV8_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_osc_on && rd_data[5]) |-> (rd_data[6] && main_drive_hold)); // R6
    AST_DECODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        {sysclk_sub, div8_sel, main_stop, sub_osc_en, sub_drive_hi, wait_pclk_stop} == rd_data[7:2]); // R8
endmodule

bind sck_reg sck_reg_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .prot_wen        (prot_wen),
    .clk_lock        (clk_lock),
    .stop_enter      (stop_enter),
    .ring_osc_on     (ring_osc_on),
    .rd_data         (rd_data),
    .sysclk_sub      (sysclk_sub),
    .div8_sel        (div8_sel),
    .main_stop       (main_stop),
    .sub_osc_en      (sub_osc_en),
    .sub_drive_hi    (sub_drive_hi),
    .wait_pclk_stop  (wait_pclk_stop),
    .main_drive_hold (main_drive_hold)
);

// File: tb/tb_sck_reg.sv
// Directed bench for sck_reg: one task per scenario, each checking itself.
module tb_sck_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       prot_wen = 1'b1;
    logic       clk_lock = 1'b0;
    logic       stop_enter = 1'b0;
    logic       ring_osc_on = 1'b1;
    logic [7:0] rd_data;
    logic       sysclk_sub, div8_sel, main_stop, sub_osc_en, sub_drive_hi, wait_pclk_stop, main_drive_hold;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sck_reg dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .prot_wen(prot_wen), .clk_lock(clk_lock), .stop_enter(stop_enter),
        .ring_osc_on(ring_osc_on), .rd_data(rd_data), .sysclk_sub(sysclk_sub),
        .div8_sel(div8_sel), .main_stop(main_stop), .sub_osc_en(sub_osc_en),
        .sub_drive_hi(sub_drive_hi), .wait_pclk_stop(wait_pclk_stop),
        .main_drive_hold(main_drive_hold)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // One write cycle, optionally with a stop pulse; samples after the edge.
    task automatic do_write(input logic [7:0] d, input logic stp);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; stop_enter = stp;
        @(negedge clk);
        wr_en = 1'b0; stop_enter = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 reset value", rd_data, 8'h48);
        chk("R1 reset hold", {7'b0, main_drive_hold}, 8'h00);
    endtask

    task automatic t_plain_write;
        do_write(8'hD7, 1'b0);
        chk("R8 write D7", rd_data, 8'hD4);
        chk("R7 reserved cleared", {6'b0, rd_data[1:0]}, 8'h00);
        chk("R8 decode", {2'b0, sysclk_sub, div8_sel, main_stop, sub_osc_en, sub_drive_hi, wait_pclk_stop},
            8'b0011_0101);
    endtask

    task automatic t_port_drive;
        do_write(8'h10, 1'b0);
        chk("R4 sub enabled, drive low", rd_data, 8'h10);
        do_write(8'h00, 1'b0);
        chk("R4 port mode forces drive", rd_data, 8'h08);
    endtask

    task automatic t_protect;
        prot_wen = 1'b0;
        do_write(8'hFF, 1'b0);
        chk("R2 unprotected write ignored", rd_data, 8'h08);
        prot_wen = 1'b1;
    endtask

    task automatic t_lock;
        clk_lock = 1'b1;
        do_write(8'hFF, 1'b0);
        chk("R3 lock keeps 7/5/2 clear", rd_data, 8'h5C & 8'hDB);
        clk_lock = 1'b0;
        do_write(8'hB4, 1'b0);
        chk("R8 unlocked write B4", rd_data, 8'hB4);
        clk_lock = 1'b1;
        do_write(8'h00, 1'b0);
        chk("R3 lock keeps 7/5/2 set", rd_data, 8'hAC);
        clk_lock = 1'b0;
    endtask

    task automatic t_stop;
        do_write(8'h10, 1'b0);
        chk("R8 setup 10", rd_data, 8'h10);
        @(negedge clk); stop_enter = 1'b1;
        @(negedge clk); stop_enter = 1'b0;
        chk("R5 stop alone", rd_data, 8'h58);
        do_write(8'h10, 1'b1);
        chk("R5 stop beats write", rd_data, 8'h58);
    endtask

    task automatic t_ring_off;
        do_write(8'h30, 1'b0);
        chk("R8 main stop, ring on", rd_data, 8'h30);
        chk("R6 no hold with ring on", {7'b0, main_drive_hold}, 8'h00);
        @(negedge clk); ring_osc_on = 1'b0;
        #1;
        chk("R6 div8 held", rd_data, 8'h70);
        chk("R6 hold output", {7'b0, main_drive_hold}, 8'h01);
        do_write(8'h30, 1'b0);
        chk("R6 div8 not cleared by write", rd_data, 8'h70);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_write();
        t_port_drive();
        t_protect();
        t_lock();
        t_stop();
        t_ring_off();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule